// File: doc/BRIEF.md
# Next-PC and Fetch Sequencer

This block holds the program counter of a five-stage scalar pipeline and drives the address port of an instruction memory that answers one cycle after it is addressed. In every cycle it chooses where the next fetch goes. The choices are the sequential address (current PC plus the 4-byte instruction step), a taken branch or jump target reported by decode, an exception handler vector, or a restart address. The word returned by memory is handed to decode together with the address it came from and a valid bit.

The branch redirect always lands after the instruction that is already in flight, which is the successor of the branch. The mode input sets what happens to that successor. In squash mode it reaches decode as an invalid NOP, which costs one cycle. In delay-slot mode it reaches decode as a live instruction. Exception and restart redirects discard the in-flight word. A stall input freezes the sequencer completely. Resolving branches, filling memory and predicting targets are done by neighbouring logic.

A small state machine tracks the word on the memory output. Its states are SLOT_BOOT (reset, nothing fetched yet), SLOT_LIVE (a word for decode), SLOT_SQUASH (the successor of a taken branch, squash mode) and SLOT_FLUSH (the word fetched in the cycle of an exception or restart). On every non-stalled edge the machine moves as follows. A restart or exception leads to SLOT_FLUSH. An accepted branch leads to SLOT_SQUASH in squash mode and to SLOT_LIVE in delay-slot mode. Every other case leads to SLOT_LIVE. A stalled edge keeps the state.

Top module: `fetch_seq`

## Requirements
- R1: While reset is asserted, and until the first edge after it, imem_addr equals the reset vector with its two low bits cleared, dec_valid is 0 and dec_instr is the NOP word (default 32'h0000_0000).
- R2: On an edge with no stall and no redirect, imem_addr advances by 4.
- R3: A word fetched at address A in cycle t appears on dec_instr in cycle t+1, with dec_pc = A and dec_valid = 1, unless that word is squashed or flushed.
- R4: When br_taken is high on a non-stalled edge while dec_valid is 1, and neither trap_req nor restart_req is high, imem_addr on the following cycle is br_target. The address presented in the branch cycle is still fetched.
- R5: With dslot_mode = 0, the word fetched in the cycle of an accepted branch reaches decode with dec_valid = 0 and dec_instr = NOP.
- R6: With dslot_mode = 1, the word fetched in the cycle of an accepted branch reaches decode with dec_valid = 1 and its own memory data.
- R7: trap_req on a non-stalled edge without restart_req sends imem_addr to trap_vec, whatever br_taken is.
- R8: restart_req on a non-stalled edge sends imem_addr to restart_pc, whatever trap_req and br_taken are.
- R9: br_taken has no effect while dec_valid is 0.
- R10: While stall is high, imem_rd is 0, and imem_addr, dec_pc, dec_valid and dec_instr keep their values over the next edge. Redirect inputs are ignored on that edge.
- R11: The two low bits of imem_addr are always 0. Redirect addresses are used with their two low bits cleared.
- R12: The word fetched in the cycle of an accepted exception or restart reaches decode with dec_valid = 0 and dec_instr = NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall | input | 1 | Freeze PC, slot state and decode outputs |
| dslot_mode | input | 1 | 0: squash branch successor, 1: execute it |
| br_taken | input | 1 | Decode reports a taken branch or jump |
| br_target | input | 32 | Branch or jump target address |
| trap_req | input | 1 | Exception redirect request |
| trap_vec | input | 32 | Exception handler address |
| restart_req | input | 1 | Restart redirect request (highest priority) |
| restart_pc | input | 32 | Restart address |
| imem_addr | output | 32 | Instruction memory address (current PC) |
| imem_rd | output | 1 | Memory read enable; memory holds its output when 0 |
| imem_rdata | input | 32 | Memory data, one cycle after the address |
| dec_instr | output | 32 | Instruction for decode, NOP when not valid |
| dec_pc | output | 32 | Address of the instruction on dec_instr |
| dec_valid | output | 1 | dec_instr is a live instruction |

## Verification
A wrong PC shows on imem_addr in the cycle right after the faulty edge. It then shows on dec_pc and dec_instr one cycle later. A slot state that is wrong only shows once decode looks at the word: a successor that should have been squashed but stays live, or a flushed word marked valid, is visible on dec_valid in the very next cycle. A branch wrongly accepted from a squashed slot is visible on imem_addr in the next cycle. The reference model in the bench is compared against every output on every clock, so each of these faults is caught within one or two cycles of its cause.

// File: rtl/fetch_seq_pkg.sv
package fetch_seq_pkg;

    // What the word on the memory output represents
    typedef enum logic [1:0] {
        SLOT_BOOT   = 2'd0,
        SLOT_LIVE   = 2'd1,
        SLOT_SQUASH = 2'd2,
        SLOT_FLUSH  = 2'd3
    } slot_state_e;

    // Source chosen for the next program counter
    typedef enum logic [1:0] {
        NPC_SEQ     = 2'd0,
        NPC_BRANCH  = 2'd1,
        NPC_TRAP    = 2'd2,
        NPC_RESTART = 2'd3
    } npc_src_e;

endpackage

// File: rtl/fetch_redirect_arb.sv
module fetch_redirect_arb
    import fetch_seq_pkg::*;
(
    input  logic     restart_req,
    input  logic     trap_req,
    input  logic     br_taken,
    input  logic     slot_live,
    output npc_src_e src
);

    // Fixed priority: restart, exception, branch (only from a live slot), sequential
    always_comb begin
        if (restart_req) begin
            src = NPC_RESTART;
        end else if (trap_req) begin
            src = NPC_TRAP;
        end else if (br_taken && slot_live) begin
            src = NPC_BRANCH;
        end else begin
            src = NPC_SEQ;
        end
    end

endmodule

// File: rtl/fetch_nextpc.sv
module fetch_nextpc
    import fetch_seq_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int STEP_BYTES = 4
) (
    input  logic [PC_W-1:0] cur_pc,
    input  npc_src_e        src,
    input  logic [PC_W-1:0] br_target,
    input  logic [PC_W-1:0] trap_vec,
    input  logic [PC_W-1:0] restart_pc,
    output logic [PC_W-1:0] next_pc
);

    localparam int ALIGN_W = $clog2(STEP_BYTES);

    logic [PC_W-1:0] raw_pc;

    always_comb begin
        unique case (src)
            NPC_RESTART: raw_pc = restart_pc;
            NPC_TRAP:    raw_pc = trap_vec;
            NPC_BRANCH:  raw_pc = br_target;
            default:     raw_pc = cur_pc + PC_W'(STEP_BYTES);
        endcase
    end

    generate
        if (ALIGN_W == 0) begin : g_no_align
            assign next_pc = raw_pc;
        end else begin : g_align
            assign next_pc = {raw_pc[PC_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
        end
    endgenerate

endmodule

// File: rtl/fetch_slot_fsm.sv
module fetch_slot_fsm
    import fetch_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        advance,
    input  npc_src_e    src,
    input  logic        dslot_mode,
    output logic        slot_live,
    output slot_state_e state
);

    slot_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SLOT_BOOT;
        end else begin
            state <= state_d;
        end
    end

    // Transitions: the redirect source decides what the word now being fetched becomes
    always_comb begin
        state_d = state;
        if (advance) begin
            unique case (src)
                NPC_RESTART,
                NPC_TRAP:   state_d = SLOT_FLUSH;
                NPC_BRANCH: state_d = dslot_mode ? SLOT_LIVE : SLOT_SQUASH;
                default:    state_d = SLOT_LIVE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (state)
            SLOT_LIVE:   slot_live = 1'b1;
            SLOT_BOOT,
            SLOT_SQUASH,
            SLOT_FLUSH:  slot_live = 1'b0;
            default:     slot_live = 1'b0;
        endcase
    end

endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
    import fetch_seq_pkg::*;
#(
    parameter int                PC_W       = 32,
    parameter int                INSN_W     = 32,
    parameter int                STEP_BYTES = 4,
    parameter logic [PC_W-1:0]   RESET_VEC  = 32'h0000_0100,
    parameter logic [INSN_W-1:0] NOP_WORD   = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              dslot_mode,
    input  logic              br_taken,
    input  logic [PC_W-1:0]   br_target,
    input  logic              trap_req,
    input  logic [PC_W-1:0]   trap_vec,
    input  logic              restart_req,
    input  logic [PC_W-1:0]   restart_pc,
    output logic [PC_W-1:0]   imem_addr,
    output logic              imem_rd,
    input  logic [INSN_W-1:0] imem_rdata,
    output logic [INSN_W-1:0] dec_instr,
    output logic [PC_W-1:0]   dec_pc,
    output logic              dec_valid
);

    localparam logic [PC_W-1:0] ALIGN_MASK = ~(PC_W'(STEP_BYTES - 1));
    localparam logic [PC_W-1:0] RESET_PC   = RESET_VEC & ALIGN_MASK;

    logic            advance;
    logic            slot_live;
    npc_src_e        src;
    slot_state_e     slot_state;
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_d;
    logic [PC_W-1:0] flight_pc_q;

    assign advance = ~stall;

    fetch_redirect_arb u_arb (
        .restart_req (restart_req),
        .trap_req    (trap_req),
        .br_taken    (br_taken),
        .slot_live   (slot_live),
        .src         (src)
    );

    fetch_nextpc #(
        .PC_W       (PC_W),
        .STEP_BYTES (STEP_BYTES)
    ) u_nextpc (
        .cur_pc     (pc_q),
        .src        (src),
        .br_target  (br_target),
        .trap_vec   (trap_vec),
        .restart_pc (restart_pc),
        .next_pc    (pc_d)
    );

    fetch_slot_fsm u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (advance),
        .src        (src),
        .dslot_mode (dslot_mode),
        .slot_live  (slot_live),
        .state      (slot_state)
    );

    // PC and the address of the word in flight
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q        <= RESET_PC;
            flight_pc_q <= '0;
        end else if (advance) begin
            pc_q        <= pc_d;
            flight_pc_q <= pc_q;
        end
    end

    assign imem_addr = pc_q;
    assign imem_rd   = advance;
    assign dec_pc    = flight_pc_q;
    assign dec_valid = slot_live;
    assign dec_instr = slot_live ? imem_rdata : NOP_WORD;

endmodule

// File: rtl/fetch_seq_chk.sv
module fetch_seq_chk #(
    parameter int                PC_W       = 32,
    parameter int                INSN_W     = 32,
    parameter int                STEP_BYTES = 4,
    parameter logic [INSN_W-1:0] NOP_WORD   = 32'h0000_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stall,
    input logic              dslot_mode,
    input logic              br_taken,
    input logic [PC_W-1:0]   br_target,
    input logic              trap_req,
    input logic [PC_W-1:0]   trap_vec,
    input logic              restart_req,
    input logic [PC_W-1:0]   restart_pc,
    input logic [PC_W-1:0]   imem_addr,
    input logic              imem_rd,
    input logic [INSN_W-1:0] dec_instr,
    input logic [PC_W-1:0]   dec_pc,
    input logic              dec_valid
);

    localparam logic [PC_W-1:0] MASK = ~(PC_W'(STEP_BYTES - 1));

    logic plain_step;
    logic br_accept;
    assign plain_step = !stall && !restart_req && !trap_req && !(br_taken && dec_valid);
    assign br_accept  = !stall && !restart_req && !trap_req && br_taken && dec_valid;

    AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_addr & ~MASK) == '0); // R11

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        plain_step |=> imem_addr == $past(imem_addr) + PC_W'(STEP_BYTES)); // R2

    AST_FLIGHT_PC: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> dec_pc == $past(imem_addr)); // R3

    AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        br_accept |=> imem_addr == ($past(br_target) & MASK)); // R4

    AST_SQUASH_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (br_accept && !dslot_mode) |=> (!dec_valid && dec_instr == NOP_WORD)); // R5

    AST_DELAY_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (br_accept && dslot_mode) |=> dec_valid); // R6

    AST_TRAP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !restart_req && trap_req) |=> imem_addr == ($past(trap_vec) & MASK)); // R7

    AST_RESTART_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && restart_req) |=> imem_addr == ($past(restart_pc) & MASK)); // R8

    AST_NO_BR_FROM_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !restart_req && !trap_req && !dec_valid) |=>
        imem_addr == $past(imem_addr) + PC_W'(STEP_BYTES)); // R9

    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(imem_addr) && $stable(dec_pc) && $stable(dec_valid))); // R10

    AST_STALL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !imem_rd); // R10

    AST_FLUSH_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && (restart_req || trap_req)) |=> !dec_valid); // R12

endmodule

bind fetch_seq fetch_seq_chk #(
    .PC_W       (PC_W),
    .INSN_W     (INSN_W),
    .STEP_BYTES (STEP_BYTES),
    .NOP_WORD   (NOP_WORD)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stall       (stall),
    .dslot_mode  (dslot_mode),
    .br_taken    (br_taken),
    .br_target   (br_target),
    .trap_req    (trap_req),
    .trap_vec    (trap_vec),
    .restart_req (restart_req),
    .restart_pc  (restart_pc),
    .imem_addr   (imem_addr),
    .imem_rd     (imem_rd),
    .dec_instr   (dec_instr),
    .dec_pc      (dec_pc),
    .dec_valid   (dec_valid)
);

// File: tb/fetch_seq_bench.sv
`timescale 1ns/1ps
module fetch_seq_bench;

    localparam logic [31:0] RV  = 32'h0000_0102;  // misaligned on purpose: R1 R11
    localparam logic [31:0] NOP = 32'h0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall = 1'b0;
    logic        dslot_mode = 1'b0;
    logic        br_taken = 1'b0;
    logic [31:0] br_target = '0;
    logic        trap_req = 1'b0;
    logic [31:0] trap_vec = '0;
    logic        restart_req = 1'b0;
    logic [31:0] restart_pc = '0;
    logic [31:0] imem_addr;
    logic        imem_rd;
    logic [31:0] imem_rdata = '0;
    logic [31:0] dec_instr;
    logic [31:0] dec_pc;
    logic        dec_valid;

    int compared = 0;
    int mismatched = 0;
    string last_tag = "R1";

    always #4 clk = ~clk;  // 125 MHz

    fetch_seq #(.RESET_VEC(RV), .NOP_WORD(NOP)) u_fetch_seq (
        .clk(clk), .rst_n(rst_n), .stall(stall), .dslot_mode(dslot_mode),
        .br_taken(br_taken), .br_target(br_target), .trap_req(trap_req),
        .trap_vec(trap_vec), .restart_req(restart_req), .restart_pc(restart_pc),
        .imem_addr(imem_addr), .imem_rd(imem_rd), .imem_rdata(imem_rdata),
        .dec_instr(dec_instr), .dec_pc(dec_pc), .dec_valid(dec_valid)
    );

    function automatic logic [31:0] word_of(logic [31:0] a);
        return {8'hC3, a[25:2]};
    endfunction

    // Memory with one cycle of read latency, holding its output when not read
    always @(posedge clk) if (imem_rd) imem_rdata <= word_of(imem_addr);

    // Behavioural reference model
    logic [31:0] m_pc;
    logic [31:0] m_fpc;
    logic        m_fvalid;
    always @(posedge clk) begin
        logic [31:0] np;
        logic        nv;
        if (!rst_n) begin
            m_pc     = RV & ~32'h3;
            m_fvalid = 1'b0;
            m_fpc    = '0;
        end else if (!stall) begin
            np = m_pc + 32'd4;
            nv = 1'b1;
            if (restart_req) begin
                np = restart_pc & ~32'h3; nv = 1'b0;
            end else if (trap_req) begin
                np = trap_vec & ~32'h3; nv = 1'b0;
            end else if (br_taken && m_fvalid) begin
                np = br_target & ~32'h3; nv = dslot_mode;
            end
            m_fpc    = m_pc;
            m_fvalid = nv;
            m_pc     = np;
        end
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", last_tag, what, act, exp);
        end
    endtask

    task automatic cmp();
        chk("imem_addr", imem_addr, m_pc);
        chk("imem_rd", {31'd0, imem_rd}, {31'd0, !stall});
        chk("dec_valid", {31'd0, dec_valid}, {31'd0, m_fvalid});
        if (m_fvalid) begin
            chk("dec_pc", dec_pc, m_fpc);
            chk("dec_instr", dec_instr, word_of(m_fpc));
        end else begin
            chk("dec_instr NOP", dec_instr, NOP);
        end
    endtask

    // One cycle: check state of the previous edge, then drive the next stimulus
    task automatic cyc(string tag, logic st, logic br, logic [31:0] bt,
                       logic tr, logic [31:0] tv, logic rs, logic [31:0] ra);
        @(negedge clk);
        cmp();
        last_tag    = tag;
        stall       = st;
        br_taken    = br;
        br_target   = bt;
        trap_req    = tr;
        trap_vec    = tv;
        restart_req = rs;
        restart_pc  = ra;
    endtask

    task automatic idle(string tag, int n);
        for (int i = 0; i < n; i++) cyc(tag, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            last_tag = "R1";
            cmp();
        end
        @(negedge clk);
        rst_n = 1'b1;
        // R2 R3: sequential fetch and one-cycle latency
        idle("R2 R3", 6);
        // R4 R5: taken branch in squash mode
        dslot_mode = 1'b0;
        cyc("R4 R5", 0, 1, 32'h0000_0400, 0, 0, 0, 0);
        // R9: branch while the squashed slot is on decode is ignored
        cyc("R9", 0, 1, 32'h0000_0800, 0, 0, 0, 0);
        idle("R9", 3);
        // R4 R6: taken branch in delay-slot mode
        dslot_mode = 1'b1;
        cyc("R4 R6", 0, 1, 32'h0000_1000, 0, 0, 0, 0);
        idle("R6", 3);
        // R7 R12: exception beats branch
        cyc("R7 R12", 0, 1, 32'h0000_2000, 1, 32'h0000_0080, 0, 0);
        idle("R7", 3);
        // R8 R12: restart beats exception and branch
        cyc("R8 R12", 0, 1, 32'h0000_2000, 1, 32'h0000_0080, 1, 32'h0000_3000);
        idle("R8", 3);
        // R10: stall with redirects pending is frozen
        cyc("R10", 1, 1, 32'h0000_4000, 1, 32'h0000_0090, 0, 0);
        cyc("R10", 1, 1, 32'h0000_4000, 0, 0, 1, 32'h0000_5000);
        cyc("R10", 1, 0, 0, 0, 0, 0, 0);
        idle("R10", 2);
        // R10 R5: stall right after a squash-mode branch
        dslot_mode = 1'b0;
        cyc("R5 R10", 0, 1, 32'h0000_6000, 0, 0, 0, 0);
        cyc("R10", 1, 0, 0, 0, 0, 0, 0);
        idle("R5", 3);
        // R11: misaligned redirect addresses
        cyc("R11", 0, 1, 32'h0000_7003, 0, 0, 0, 0);
        idle("R11", 2);
        cyc("R11", 0, 0, 0, 1, 32'h0000_00A2, 0, 0);
        idle("R11", 2);
        cyc("R11", 0, 0, 0, 0, 0, 1, 32'h0000_8001);
        idle("R11", 2);
        // Mixed traffic: R2 R4 R7 R8 R10
        for (int i = 0; i < 400; i++) begin
            if (i % 50 == 0) dslot_mode = $urandom_range(0, 1) == 1;
            cyc("R2 R4 R7 R8 R10",
                $urandom_range(0, 5) == 0,
                $urandom_range(0, 3) == 0, $urandom,
                $urandom_range(0, 15) == 0, $urandom,
                $urandom_range(0, 31) == 0, $urandom);
        end
        idle("R2", 2);
        @(negedge clk);
        cmp();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule